// File: doc/BRIEF.md
# Byte and Halfword Shuffle Unit

This unit rearranges the bytes or halfwords of a 64-bit operand, or sign-extends its lowest byte or halfword, in one clocked step. The caller presents an operand, a 3-bit operation code and a valid strobe. One clock later the unit shows the 64-bit result together with a register write enable. If the code is not one of the five defined operations, the unit raises an invalid flag in place of the write enable.

There are five operations. The first swaps the two bytes inside each halfword of the low 32 bits and sign-extends the 32-bit result to 64 bits. The second performs the same byte swap across all four halfwords and applies no extension. The third reverses the order of the four halfwords. The last two replicate bit 7 or bit 15 of the operand into every higher bit. An unrecognised code behaves as a reserved instruction: the result is forced to zero and nothing is written.

The datapath holds no state between operations. It has a single registered stage whose states are idle (no strobe), write (a defined code) and reject (an undefined code). Each clock picks one of these from the strobe and the code presented on the previous edge.

Top module: `bsh_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `res_o` is zero and `wr_o` and `err_o` are low.
- R2: Code 0 (word byte swap) gives bytes [b2 b3 b0 b1] of the operand in the low 32 bits of `res_o`, with bits 63:32 copies of the new bit 31.
- R3: Code 1 (doubleword byte swap) exchanges the two bytes of every 16-bit lane of the operand and applies no sign extension.
- R4: Code 2 (halfword reversal) places operand halfword k (bits 16k+15:16k) in result halfword 3-k, for k = 0 to 3.
- R5: Code 3 (byte sign extension) gives operand bits 7:0 in result bits 7:0, with bit 7 copied into bits 63:8.
- R6: Code 4 (halfword sign extension) gives operand bits 15:0 in result bits 15:0, with bit 15 copied into bits 63:16.
- R7: Codes 5, 6 and 7 set `err_o`, drive `res_o` to zero and keep `wr_o` low.
- R8: Results appear exactly one clock edge after `in_valid_i` is sampled high. A cycle with `in_valid_i` low yields zero `res_o` and low `wr_o` and `err_o` on the next edge.
- R9: `wr_o` and `err_o` are never high together, and exactly one of them is high after each accepted strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code (0 to 4 defined) |
| opnd_i | input | 64 | Source operand |
| res_o | output | 64 | Registered result |
| wr_o | output | 1 | Result write enable |
| err_o | output | 1 | Reserved-code flag |

## Verification
The bench targets a word swap whose new bit 31 is set; a design that sign-extends from the wrong bit, or not at all, shows a zero upper word there. It also drives sign-extension operands that sit exactly on the 0x7F/0x80 and 0x7FFF/0x8000 boundaries, where extending from an off-by-one bit flips the whole upper field. Halfword reversal is tested with four distinct halfwords, so swapping only the two halves or only the adjacent pairs becomes visible. Reserved codes are applied with all-ones operands, so a result that leaks through instead of being zeroed shows up at the port.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
    localparam int OP_W   = 3;
    localparam int DATA_W = 64;

    typedef enum logic [OP_W-1:0] {
        OP_SWB_W = 3'd0,
        OP_SWB_D = 3'd1,
        OP_HREV  = 3'd2,
        OP_SXB   = 3'd3,
        OP_SXH   = 3'd4
    } bsh_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_REJECT = 2'd2
    } bsh_state_e;
endpackage

// File: rtl/bsh_decode.sv
module bsh_decode
    import bsh_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output logic            sel_swbw_o,
    output logic            sel_swbd_o,
    output logic            sel_hrev_o,
    output logic            sel_sxb_o,
    output logic            sel_sxh_o,
    output logic            bad_o
);
    always_comb begin
        sel_swbw_o = 1'b0;
        sel_swbd_o = 1'b0;
        sel_hrev_o = 1'b0;
        sel_sxb_o  = 1'b0;
        sel_sxh_o  = 1'b0;
        bad_o      = 1'b0;
        unique case (op_i)
            OP_SWB_W: sel_swbw_o = 1'b1;
            OP_SWB_D: sel_swbd_o = 1'b1;
            OP_HREV:  sel_hrev_o = 1'b1;
            OP_SXB:   sel_sxb_o  = 1'b1;
            OP_SXH:   sel_sxh_o  = 1'b1;
            default:  bad_o      = 1'b1;
        endcase
    end
endmodule

// File: rtl/bsh_lanes.sv
module bsh_lanes #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 16
) (
    input  logic [DATA_W-1:0] x_i,
    output logic [DATA_W-1:0] bswap_o,
    output logic [DATA_W-1:0] hrev_o
);
    localparam int N_LANES = DATA_W / LANE_W;
    localparam int HALF_W  = LANE_W / 2;

    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        assign bswap_o[k*LANE_W +: LANE_W] =
            {x_i[k*LANE_W +: HALF_W], x_i[k*LANE_W + HALF_W +: HALF_W]};
        assign hrev_o[k*LANE_W +: LANE_W] =
            x_i[(N_LANES-1-k)*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/bsh_sext.sv
module bsh_sext #(
    parameter int DATA_W = 64,
    parameter int SRC_W  = 8
) (
    input  logic [SRC_W-1:0]  x_i,
    output logic [DATA_W-1:0] y_o
);
    localparam int FILL_W = DATA_W - SRC_W;
    assign y_o = {{FILL_W{x_i[SRC_W-1]}}, x_i};
endmodule

// File: rtl/bsh_unit.sv
module bsh_unit
    import bsh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] opnd_i,
    output logic [DATA_W-1:0] res_o,
    output logic              wr_o,
    output logic              err_o
);
    localparam int WORD_W = DATA_W / 2;

    logic sel_swbw, sel_swbd, sel_hrev, sel_sxb, sel_sxh, bad;
    logic [DATA_W-1:0] bswap, hrev, sxb, sxh, res_nxt;
    bsh_state_e st_q, st_nxt;
    logic [DATA_W-1:0] res_q;

    bsh_decode u_dec (
        .op_i       (op_i),
        .sel_swbw_o (sel_swbw),
        .sel_swbd_o (sel_swbd),
        .sel_hrev_o (sel_hrev),
        .sel_sxb_o  (sel_sxb),
        .sel_sxh_o  (sel_sxh),
        .bad_o      (bad)
    );

    bsh_lanes #(.DATA_W(DATA_W), .LANE_W(16)) u_lanes (
        .x_i     (opnd_i),
        .bswap_o (bswap),
        .hrev_o  (hrev)
    );

    bsh_sext #(.DATA_W(DATA_W), .SRC_W(8)) u_sxb (
        .x_i (opnd_i[7:0]),
        .y_o (sxb)
    );

    bsh_sext #(.DATA_W(DATA_W), .SRC_W(16)) u_sxh (
        .x_i (opnd_i[15:0]),
        .y_o (sxh)
    );

    always_comb begin
        res_nxt = '0;
        st_nxt  = ST_IDLE;
        if (in_valid_i) begin
            if (bad) begin
                st_nxt = ST_REJECT;
            end else begin
                st_nxt = ST_WRITE;
                res_nxt = ({DATA_W{sel_swbw}} & {{WORD_W{bswap[WORD_W-1]}}, bswap[WORD_W-1:0]})
                        | ({DATA_W{sel_swbd}} & bswap)
                        | ({DATA_W{sel_hrev}} & hrev)
                        | ({DATA_W{sel_sxb}}  & sxb)
                        | ({DATA_W{sel_sxh}}  & sxh);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            res_q <= '0;
        end else begin
            st_q  <= st_nxt;
            res_q <= res_nxt;
        end
    end

    always_comb begin
        res_o = res_q;
        wr_o  = 1'b0;
        err_o = 1'b0;
        unique case (st_q)
            ST_WRITE:  wr_o  = 1'b1;
            ST_REJECT: err_o = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/bsh_unit_chk.sv
module bsh_unit_chk
    import bsh_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid_i,
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] opnd_i,
    input logic [DATA_W-1:0] res_o,
    input logic              wr_o,
    input logic              err_o
);
    // R7
    rsv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (res_o == '0 && !wr_o));

    // R9
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_o && err_o));

    // R8
    one_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> (wr_o || err_o));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> (!wr_o && !err_o && res_o == '0));

    // R4
    hrev_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && op_i == OP_HREV) |=> res_o[15:0] == $past(opnd_i[63:48]));

    // R5
    sxb_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && op_i == OP_SXB) |=> res_o[63] == $past(opnd_i[7]));
endmodule

bind bsh_unit bsh_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid_i (in_valid_i),
    .op_i       (op_i),
    .opnd_i     (opnd_i),
    .res_o      (res_o),
    .wr_o       (wr_o),
    .err_o      (err_o)
);

// File: tb/sim_bsh_unit.sv
module sim_bsh_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [63:0] opnd_i = '0;
    logic [63:0] res_o;
    logic        wr_o, err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bsh_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .op_i(op_i),
        .opnd_i(opnd_i), .res_o(res_o), .wr_o(wr_o), .err_o(err_o)
    );

    function automatic logic [63:0] model(input int op, input logic [63:0] x);
        logic [7:0] b [8];
        logic [63:0] r;
        for (int i = 0; i < 8; i++) b[i] = x[8*i +: 8];
        r = '0;
        case (op)
            0: begin
                r[31:0] = {b[2], b[3], b[0], b[1]};
                for (int i = 32; i < 64; i++) r[i] = r[31];
            end
            1: r = {b[6], b[7], b[4], b[5], b[2], b[3], b[0], b[1]};
            2: r = {x[15:0], x[31:16], x[47:32], x[63:48]};
            3: begin
                r[7:0] = b[0];
                for (int i = 8; i < 64; i++) r[i] = x[7];
            end
            4: begin
                r[15:0] = x[15:0];
                for (int i = 16; i < 64; i++) r[i] = x[15];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic expect_out(input string tag, input logic [63:0] er,
                              input logic ew, input logic ee);
        n_chk++;
        if (res_o !== er || wr_o !== ew || err_o !== ee) begin
            n_bad++;
            $display("FAIL %s: res=%h wr=%b err=%b expected res=%h wr=%b err=%b",
                     tag, res_o, wr_o, err_o, er, ew, ee);
        end
    endtask

    // call at a negedge; checks at the following negedge
    task automatic apply(input string tag, input bit v, input int op, input logic [63:0] x);
        logic [63:0] er;
        logic ew, ee;
        in_valid_i = v;
        op_i = 3'(op);
        opnd_i = x;
        ee = v && (op > 4);
        ew = v && (op <= 4);
        er = (v && op <= 4) ? model(op, x) : 64'd0;
        @(negedge clk);
        expect_out(tag, er, ew, ee);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expect_out("R1 in reset", 64'd0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 after reset", 64'd0, 1'b0, 1'b0);

        apply("R2 sign bit set",   1, 0, 64'h1234_5678_0080_0011);
        apply("R2 sign bit clear", 1, 0, 64'hFFFF_FFFF_8000_0000);
        apply("R3 lanes",          1, 1, 64'h0102_0304_0506_0708);
        apply("R4 distinct",       1, 2, 64'h1111_2222_3333_4444);
        apply("R5 0x80",           1, 3, 64'h0000_0000_0000_0080);
        apply("R5 0x7F",           1, 3, 64'hFFFF_FFFF_FFFF_FF7F);
        apply("R6 0x8000",         1, 4, 64'h0000_0000_0000_8000);
        apply("R6 0x7FFF",         1, 4, 64'hFFFF_FFFF_FFFF_7FFF);
        apply("R7 code5",          1, 5, 64'hFFFF_FFFF_FFFF_FFFF);
        apply("R7 code6",          1, 6, 64'hFFFF_FFFF_FFFF_FFFF);
        apply("R7 code7",          1, 7, 64'hFFFF_FFFF_FFFF_FFFF);
        apply("R8 idle",           0, 1, 64'hDEAD_BEEF_CAFE_F00D);
        apply("R9 write after rsv",1, 2, 64'hA5A5_5A5A_0F0F_F0F0);

        for (int op = 0; op < 8; op++) begin
            for (int n = 0; n < 40; n++) begin
                logic [63:0] x;
                x = {$urandom, $urandom};
                case (op)
                    0: apply("R2 random", 1, op, x);
                    1: apply("R3 random", 1, op, x);
                    2: apply("R4 random", 1, op, x);
                    3: apply("R5 random", 1, op, x);
                    4: apply("R6 random", 1, op, x);
                    default: apply("R7 random", 1, op, x);
                endcase
                if (n % 7 == 3) apply("R8 gap", 0, op, x);
            end
        end
        in_valid_i = 1'b0;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule